// File: doc/BRIEF.md
# Double-Banked Burst Histogram Counter Store

This block keeps a histogram of traffic bursts. Each bin holds three counters: a 64-bit packet total, a 64-bit byte total and a 32-bit count of bursts. An upstream classifier presents one finished burst per cycle at most, giving its bin, its packet count and its byte count. The block adds the burst into the matching bin of the active bank. This is a read-modify-write through a memory with a registered read. A result that is still being written is forwarded, so updates on consecutive cycles to the same bin are all kept.

There are two banks. A host readout request swaps their roles in a single cycle. The bank that was counting becomes frozen, and the other bank takes over counting after being emptied. Emptying uses one valid bit per bin, cleared all at once, so counting never pauses. The host reads the frozen bank one bin at a time through fixed register offsets and steps to the next bin with an acknowledge strobe. Every value read therefore belongs to the same instant.

A small register interface also holds the maximum gap value used upstream. It provides a configuration mode that hands bin limit words, with their index, to the classifier.

The readout machine has four states:
- `RD_IDLE`: no readout is running.
- `RD_DRAIN`: the swap cycle, during which old-bank writes still in flight complete.
- `RD_FETCH`: the frozen bin is being read.
- `RD_SHOW`: the values are stable at the registers.

Its transitions are:
- `RD_IDLE` to `RD_DRAIN` on a start request.
- `RD_DRAIN` to `RD_FETCH` always.
- `RD_FETCH` to `RD_SHOW` always.
- `RD_SHOW` to `RD_FETCH` on an acknowledge.
- `RD_SHOW` to `RD_IDLE` on the acknowledge of the last bin.

The configuration machine has two states, `CF_IDLE` and `CF_LOAD`:
- `CF_IDLE` to `CF_LOAD` on a start request.
- `CF_LOAD` to `CF_IDLE` on the acknowledge of the last index.

A soft reset forces both machines to idle.

Top module: `hist_bank_store`

## Requirements
- R1: After reset the control register (offset 0x00) and the gap register (offset 0x08) read 0, `meas_en` is 0 and `cfg_valid` is 0.
- R2: While control bit 0 is 1, an update adds `upd_pkts` to the 64-bit packet counter and `upd_bytes` to the 64-bit byte counter of bin `upd_bin` in the active bank, and adds 1 to its 32-bit burst counter. While the bit is 0, updates leave every counter unchanged.
- R3: Updates presented on consecutive cycles, to the same bin or to different bins, are all counted with none lost.
- R4: Writing the control register with bit 1 set while no readout runs swaps the banks in that cycle. The frozen bank keeps its values, the new active bank starts from zero, and counting continues during the readout.
- R5: During readout the current bin is shown at these offsets: burst count at 0x10, byte count low and high words at 0x14 and 0x18, and packet count low and high words at 0x20 and 0x24. The values are stable from the third cycle after the start write and from the second cycle after an acknowledge.
- R6: Readout begins at bin 0. Writing bit 0 of the acknowledge register (offset 0x04) steps to the next bin. The acknowledge of bin 255 ends the readout, clears control bit 1 and returns the pointer to bin 0.
- R7: Control reads back as follows: bit 0 is the enable, bit 1 is set while a readout runs, bit 2 is set while configuration runs, and all other bits are 0. Writing 0x3 starts a readout and keeps counting enabled.
- R8: Writing control bit 2 starts configuration at index 0. While configuration runs, a write to offset 0x0C raises `cfg_valid` in the same cycle, with `cfg_index` set to the current index and `cfg_value` set to the written word. Bit 1 of the acknowledge register advances the index. After the acknowledge of index 255, bit 2 clears. Outside configuration, writes to 0x0C raise nothing.
- R9: The gap register at 0x08 keeps the low 16 bits of a write, reads them back and drives `gap_limit`.
- R10: Writing control bit 7 empties both banks, clears the enable, ends any readout or configuration, makes the next readout start at bin 0 and reads back as 0. The gap register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | A classified burst is presented |
| upd_bin | input | 8 | Bin of the burst |
| upd_pkts | input | 32 | Packets in the burst |
| upd_bytes | input | 32 | Bytes in the burst |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| meas_en | output | 1 | Counting enabled |
| gap_limit | output | 16 | Maximum in-burst gap for the upstream sampler |
| cfg_valid | output | 1 | Bin limit word strobe |
| cfg_index | output | 8 | Bin index of the limit word |
| cfg_value | output | 32 | Limit word |

## Verification
Back-to-back updates to the same bin are aimed at the forwarding path. If forwarding were missing, the second burst would read a stale total and the earlier ones would vanish from the readout. Byte values near 2^32 repeated on one bin check that the carry reaches the high word, which a truncated adder would drop.

Updates keep arriving during a readout, and a second readout follows. A bank that was not emptied on swap would show the old totals again. A swap that let writes leak into the frozen bank would change values mid-readout. A pointer that did not wrap would start the second pass at the wrong bin.

A soft reset followed by a readout must show all zeros. Configuration must end after exactly 256 acknowledges, with the control register reading 0.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    localparam int PKT_W   = 64;
    localparam int BYTE_W  = 64;
    localparam int BURST_W = 32;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int GAP_W   = 16;

    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_GAP     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_BINCFG  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_BURST   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_BYTE_LO = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_BYTE_HI = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_PKT_LO  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_PKT_HI  = 8'h24;

    localparam int CTL_EN  = 0;
    localparam int CTL_RD  = 1;
    localparam int CTL_CFG = 2;
    localparam int CTL_RST = 7;
    localparam int ACK_RD  = 0;
    localparam int ACK_CFG = 1;

    typedef struct packed {
        logic [PKT_W-1:0]   pkts;
        logic [BYTE_W-1:0]  bytes;
        logic [BURST_W-1:0] bursts;
    } bin_cnt_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_DRAIN,
        RD_FETCH,
        RD_SHOW
    } rd_state_t;

    typedef enum logic {
        CF_IDLE,
        CF_LOAD
    } cf_state_t;

endpackage

// File: rtl/hbs_ram.sv
module hbs_ram
    import hbs_pkg::*;
#(
    parameter int NBINS = 256,
    localparam int BIN_W = $clog2(NBINS),
    localparam int DEPTH = 2 * NBINS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [BIN_W-1:0] wr_bin,
    input  bin_cnt_t         wr_data,
    input  logic             ra_bank,
    input  logic [BIN_W-1:0] ra_bin,
    output bin_cnt_t         ra_data,
    output logic             ra_vld,
    input  logic             rb_bank,
    input  logic [BIN_W-1:0] rb_bin,
    output bin_cnt_t         rb_data,
    output logic             rb_vld,
    input  logic             clr_en,
    input  logic             clr_bank,
    input  logic             clr_all
);

    bin_cnt_t         mem [DEPTH];
    logic [DEPTH-1:0] vld;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[{wr_bank, wr_bin}] <= wr_data;
        end
        ra_data <= mem[{ra_bank, ra_bin}];
        rb_data <= mem[{rb_bank, rb_bin}];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            vld    <= '0;
            ra_vld <= 1'b0;
            rb_vld <= 1'b0;
        end else begin
            if (clr_en) begin
                vld[{clr_bank, {BIN_W{1'b0}}} +: NBINS] <= '0;
            end
            if (wr_en) begin
                vld[{wr_bank, wr_bin}] <= 1'b1;
            end
            ra_vld <= vld[{ra_bank, ra_bin}];
            rb_vld <= vld[{rb_bank, rb_bin}];
        end
    end

    AST_CLR_SPARES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && wr_en) |-> (wr_bank != clr_bank)); // R4

endmodule

// File: rtl/hbs_rmw.sv
module hbs_rmw
    import hbs_pkg::*;
#(
    parameter int NBINS = 256,
    parameter int UPD_W = 32,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             meas_en,
    input  logic             upd_valid,
    input  logic [BIN_W-1:0] upd_bin,
    input  logic [UPD_W-1:0] upd_pkts,
    input  logic [UPD_W-1:0] upd_bytes,
    input  logic             act_bank,
    output logic             ra_bank,
    output logic [BIN_W-1:0] ra_bin,
    input  bin_cnt_t         ra_data,
    input  logic             ra_vld,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [BIN_W-1:0] wr_bin,
    output bin_cnt_t         wr_data
);

    logic             accept;
    logic             s1_valid;
    logic             s1_bank;
    logic [BIN_W-1:0] s1_bin;
    logic [UPD_W-1:0] s1_pkts;
    logic [UPD_W-1:0] s1_bytes;

    logic             lw_valid;
    logic             lw_bank;
    logic [BIN_W-1:0] lw_bin;
    bin_cnt_t         lw_data;

    logic             fwd_hit;
    bin_cnt_t         base;

    assign accept  = upd_valid && meas_en && !flush;
    assign ra_bank = act_bank;
    assign ra_bin  = upd_bin;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= accept;
        end
        s1_bank  <= act_bank;
        s1_bin   <= upd_bin;
        s1_pkts  <= upd_pkts;
        s1_bytes <= upd_bytes;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            lw_valid <= 1'b0;
        end else begin
            lw_valid <= wr_en;
        end
        lw_bank <= wr_bank;
        lw_bin  <= wr_bin;
        lw_data <= wr_data;
    end

    always_comb begin
        fwd_hit = lw_valid && (lw_bank == s1_bank) && (lw_bin == s1_bin);
        if (fwd_hit) begin
            base = lw_data;
        end else if (ra_vld) begin
            base = ra_data;
        end else begin
            base = '0;
        end
        wr_en          = s1_valid && !flush;
        wr_bank        = s1_bank;
        wr_bin         = s1_bin;
        wr_data.pkts   = base.pkts + PKT_W'(s1_pkts);
        wr_data.bytes  = base.bytes + BYTE_W'(s1_bytes);
        wr_data.bursts = base.bursts + BURST_W'(1);
    end

    AST_FWD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && fwd_hit) |-> $past(wr_en)); // R3

    AST_WRITE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(upd_valid && meas_en)); // R2

endmodule

// File: rtl/hbs_host.sv
module hbs_host
    import hbs_pkg::*;
#(
    parameter int NBINS = 256,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              meas_en,
    output logic [GAP_W-1:0]  gap_limit,
    output logic              cfg_valid,
    output logic [BIN_W-1:0]  cfg_index,
    output logic [REG_W-1:0]  cfg_value,
    output logic              act_bank,
    output logic              rb_bank,
    output logic [BIN_W-1:0]  rb_bin,
    input  bin_cnt_t          rb_data,
    input  logic              rb_vld,
    output logic              soft_rst,
    output logic              swap_clr,
    output logic              swap_bank,
    output logic              rd_settled
);

    localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NBINS - 1);

    rd_state_t        rd_state, rd_next;
    cf_state_t        cf_state, cf_next;
    logic             en_q;
    logic             act_q;
    logic [BIN_W-1:0] rd_ptr;
    logic [BIN_W-1:0] cf_idx;
    logic [GAP_W-1:0] gap_q;

    logic     wr_ctrl, wr_ack, wr_gap, wr_bincfg;
    logic     rd_start, rd_step, rd_last;
    logic     cfg_start, cfg_step, cfg_last;
    bin_cnt_t shown;

    always_comb begin
        wr_ctrl   = reg_we && (reg_addr == OFS_CTRL);
        wr_ack    = reg_we && (reg_addr == OFS_ACK);
        wr_gap    = reg_we && (reg_addr == OFS_GAP);
        wr_bincfg = reg_we && (reg_addr == OFS_BINCFG);
        soft_rst  = wr_ctrl && reg_wdata[CTL_RST];
        rd_start  = wr_ctrl && !soft_rst && reg_wdata[CTL_RD] && (rd_state == RD_IDLE);
        rd_step   = wr_ack && reg_wdata[ACK_RD] && (rd_state == RD_SHOW);
        rd_last   = (rd_ptr == LAST_BIN);
        cfg_start = wr_ctrl && !soft_rst && reg_wdata[CTL_CFG] && (cf_state == CF_IDLE);
        cfg_step  = wr_ack && reg_wdata[ACK_CFG] && (cf_state == CF_LOAD);
        cfg_last  = (cf_idx == LAST_BIN);
    end

    // readout machine: next state
    always_comb begin
        rd_next = rd_state;
        unique case (rd_state)
            RD_IDLE:  if (rd_start) rd_next = RD_DRAIN;
            RD_DRAIN: rd_next = RD_FETCH;
            RD_FETCH: rd_next = RD_SHOW;
            RD_SHOW:  if (rd_step) rd_next = rd_last ? RD_IDLE : RD_FETCH;
        endcase
        if (soft_rst) begin
            rd_next = RD_IDLE;
        end
    end

    // configuration machine: next state
    always_comb begin
        cf_next = cf_state;
        unique case (cf_state)
            CF_IDLE: if (cfg_start) cf_next = CF_LOAD;
            CF_LOAD: if (cfg_step && cfg_last) cf_next = CF_IDLE;
        endcase
        if (soft_rst) begin
            cf_next = CF_IDLE;
        end
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_state <= RD_IDLE;
            cf_state <= CF_IDLE;
        end else begin
            rd_state <= rd_next;
            cf_state <= cf_next;
        end
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            act_q  <= 1'b0;
            rd_ptr <= '0;
            cf_idx <= '0;
            gap_q  <= '0;
        end else if (soft_rst) begin
            en_q   <= 1'b0;
            act_q  <= 1'b0;
            rd_ptr <= '0;
            cf_idx <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= reg_wdata[CTL_EN];
            end
            if (rd_start) begin
                act_q <= ~act_q;
            end
            if (rd_step) begin
                rd_ptr <= rd_last ? '0 : rd_ptr + 1'b1;
            end
            if (cfg_start) begin
                cf_idx <= '0;
            end else if (cfg_step) begin
                cf_idx <= cf_idx + 1'b1;
            end
            if (wr_gap) begin
                gap_q <= reg_wdata[GAP_W-1:0];
            end
        end
    end

    // outputs
    always_comb begin
        shown      = rb_vld ? rb_data : '0;
        meas_en    = en_q;
        gap_limit  = gap_q;
        act_bank   = act_q;
        rb_bank    = ~act_q;
        rb_bin     = rd_ptr;
        swap_clr   = rd_start;
        swap_bank  = ~act_q;
        rd_settled = (rd_state == RD_FETCH) || (rd_state == RD_SHOW);
        cfg_valid  = wr_bincfg && (cf_state == CF_LOAD);
        cfg_index  = cf_idx;
        cfg_value  = reg_wdata;
        reg_rdata  = '0;
        case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[CTL_EN]  = en_q;
                reg_rdata[CTL_RD]  = (rd_state != RD_IDLE);
                reg_rdata[CTL_CFG] = (cf_state == CF_LOAD);
            end
            OFS_GAP:     reg_rdata = REG_W'(gap_q);
            OFS_BURST:   reg_rdata = shown.bursts;
            OFS_BYTE_LO: reg_rdata = shown.bytes[REG_W-1:0];
            OFS_BYTE_HI: reg_rdata = shown.bytes[BYTE_W-1:REG_W];
            OFS_PKT_LO:  reg_rdata = shown.pkts[REG_W-1:0];
            OFS_PKT_HI:  reg_rdata = shown.pkts[PKT_W-1:REG_W];
            default:     reg_rdata = '0;
        endcase
    end

    AST_SWAP_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> (act_q != $past(act_q))); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !rd_last && !soft_rst) |=> (rd_ptr == BIN_W'($past(rd_ptr) + 1'b1))); // R6

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && rd_last) |=> ((rd_ptr == '0) && (rd_state == RD_IDLE))); // R6

    AST_CFG_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_step && cfg_last) |=> (cf_state == CF_IDLE)); // R8

    AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!en_q && (rd_state == RD_IDLE) && (cf_state == CF_IDLE))); // R10

endmodule

// File: rtl/hist_bank_store.sv
module hist_bank_store
    import hbs_pkg::*;
#(
    parameter int NBINS = 256,
    parameter int UPD_W = 32,
    localparam int BIN_W = $clog2(NBINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [BIN_W-1:0]  upd_bin,
    input  logic [UPD_W-1:0]  upd_pkts,
    input  logic [UPD_W-1:0]  upd_bytes,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              meas_en,
    output logic [GAP_W-1:0]  gap_limit,
    output logic              cfg_valid,
    output logic [BIN_W-1:0]  cfg_index,
    output logic [REG_W-1:0]  cfg_value
);

    logic             act_bank;
    logic             rb_bank;
    logic [BIN_W-1:0] rb_bin;
    bin_cnt_t         rb_data;
    logic             rb_vld;
    logic             soft_rst;
    logic             swap_clr;
    logic             swap_bank;
    logic             rd_settled;

    logic             ra_bank;
    logic [BIN_W-1:0] ra_bin;
    bin_cnt_t         ra_data;
    logic             ra_vld;
    logic             wr_en;
    logic             wr_bank;
    logic [BIN_W-1:0] wr_bin;
    bin_cnt_t         wr_data;

    hbs_host #(.NBINS(NBINS)) i_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .meas_en    (meas_en),
        .gap_limit  (gap_limit),
        .cfg_valid  (cfg_valid),
        .cfg_index  (cfg_index),
        .cfg_value  (cfg_value),
        .act_bank   (act_bank),
        .rb_bank    (rb_bank),
        .rb_bin     (rb_bin),
        .rb_data    (rb_data),
        .rb_vld     (rb_vld),
        .soft_rst   (soft_rst),
        .swap_clr   (swap_clr),
        .swap_bank  (swap_bank),
        .rd_settled (rd_settled)
    );

    hbs_rmw #(.NBINS(NBINS), .UPD_W(UPD_W)) i_rmw (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (soft_rst),
        .meas_en   (meas_en),
        .upd_valid (upd_valid),
        .upd_bin   (upd_bin),
        .upd_pkts  (upd_pkts),
        .upd_bytes (upd_bytes),
        .act_bank  (act_bank),
        .ra_bank   (ra_bank),
        .ra_bin    (ra_bin),
        .ra_data   (ra_data),
        .ra_vld    (ra_vld),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_bin    (wr_bin),
        .wr_data   (wr_data)
    );

    hbs_ram #(.NBINS(NBINS)) i_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_bin   (wr_bin),
        .wr_data  (wr_data),
        .ra_bank  (ra_bank),
        .ra_bin   (ra_bin),
        .ra_data  (ra_data),
        .ra_vld   (ra_vld),
        .rb_bank  (rb_bank),
        .rb_bin   (rb_bin),
        .rb_data  (rb_data),
        .rb_vld   (rb_vld),
        .clr_en   (swap_clr),
        .clr_bank (swap_bank),
        .clr_all  (soft_rst)
    );

    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_settled) |-> (wr_bank == act_bank)); // R4

endmodule

// File: tb/test_hist_bank_store.sv
module test_hist_bank_store;

    localparam int CLK_P = 20;
    localparam int NB    = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [7:0]  upd_bin = '0;
    logic [31:0] upd_pkts = '0;
    logic [31:0] upd_bytes = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        meas_en;
    logic [15:0] gap_limit;
    logic        cfg_valid;
    logic [7:0]  cfg_index;
    logic [31:0] cfg_value;

    always #(CLK_P/2) clk = ~clk;

    hist_bank_store i_hist_bank_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_valid (upd_valid),
        .upd_bin   (upd_bin),
        .upd_pkts  (upd_pkts),
        .upd_bytes (upd_bytes),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .meas_en   (meas_en),
        .gap_limit (gap_limit),
        .cfg_valid (cfg_valid),
        .cfg_index (cfg_index),
        .cfg_value (cfg_value)
    );

    typedef struct {
        int              bin;
        longint unsigned pk;
        longint unsigned by;
        int unsigned     bu;
    } exp_t;

    exp_t            sbq[$];
    longint unsigned m_pk [2*NB];
    longint unsigned m_by [2*NB];
    int unsigned     m_bu [2*NB];
    int              m_act = 0;
    bit              en_model = 0;
    int              n_chk = 0;
    int              n_fail = 0;
    bit              done = 0;

    task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input int bin, input int unsigned pk, input int unsigned by);
        @(negedge clk);
        upd_valid = 1'b1; upd_bin = bin[7:0]; upd_pkts = pk; upd_bytes = by;
        if (en_model) begin
            m_pk[m_act*NB + bin] += longint'(pk);
            m_by[m_act*NB + bin] += longint'(by);
            m_bu[m_act*NB + bin] += 1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            upd_valid = 1'b0;
        end
    endtask

    task automatic model_clear_all();
        for (int i = 0; i < 2*NB; i++) begin
            m_pk[i] = 0; m_by[i] = 0; m_bu[i] = 0;
        end
        m_act = 0;
    endtask

    // driver: starts readout and pushes the frozen bank into the scoreboard
    task automatic start_readout();
        exp_t e;
        reg_write(8'h00, en_model ? 32'h3 : 32'h2);
        for (int b = 0; b < NB; b++) begin
            e.bin = b;
            e.pk  = m_pk[m_act*NB + b];
            e.by  = m_by[m_act*NB + b];
            e.bu  = m_bu[m_act*NB + b];
            sbq.push_back(e);
        end
        m_act = 1 - m_act;
        for (int b = 0; b < NB; b++) begin
            m_pk[m_act*NB + b] = 0; m_by[m_act*NB + b] = 0; m_bu[m_act*NB + b] = 0;
        end
    endtask

    // monitor: pops expectations and compares with the shown bin
    task automatic drain_readout(input string tag);
        logic [31:0] bu, blo, bhi, plo, phi;
        exp_t e;
        @(negedge clk);
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            reg_read(8'h10, bu);
            reg_read(8'h14, blo);
            reg_read(8'h18, bhi);
            reg_read(8'h20, plo);
            reg_read(8'h24, phi);
            e = sbq.pop_front();
            check($sformatf("%s bin %0d pk/by/bu", tag, e.bin),
                  {32'h0, phi, plo, bhi, blo, bu},
                  {32'h0, e.pk, e.by, e.bu});
            reg_write(8'h04, 32'h1);
            @(negedge clk);
        end
    endtask

    logic [31:0] rd;

    initial begin
        model_clear_all();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        reg_read(8'h00, rd); check("R1 ctrl", 192'(rd), 192'(0));
        reg_read(8'h08, rd); check("R1 gap", 192'(rd), 192'(0));
        check("R1 meas_en", 192'(meas_en), 192'(0));
        check("R1 cfg_valid", 192'(cfg_valid), 192'(0));

        // R9 gap register
        reg_write(8'h08, 32'h1234);
        reg_read(8'h08, rd); check("R9 gap readback", 192'(rd), 192'(32'h1234));
        check("R9 gap_limit", 192'(gap_limit), 192'(16'h1234));
        reg_write(8'h08, 32'hABCD_0015);
        reg_read(8'h08, rd); check("R9 gap low half", 192'(rd), 192'(32'h15));

        // R8 write to bin config outside configuration raises nothing
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'h55;
        #1 check("R8 cfg idle no strobe", 192'(cfg_valid), 192'(0));
        @(negedge clk); reg_we = 1'b0;

        // R8 configuration pass
        reg_write(8'h00, 32'h4);
        reg_read(8'h00, rd); check("R7 R8 ctrl cfg busy", 192'(rd), 192'(32'h4));
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            reg_we = 1'b1; reg_addr = 8'h0C; reg_wdata = 32'(100 * (i + 1));
            #1;
            if (i < 2 || i == NB - 1) begin
                check("R8 cfg strobe", {cfg_valid, cfg_index, cfg_value},
                      {1'b1, 8'(i), 32'(100 * (i + 1))});
            end
            @(negedge clk); reg_we = 1'b0;
            reg_write(8'h04, 32'h2);
        end
        reg_read(8'h00, rd); check("R8 ctrl zero after config", 192'(rd), 192'(0));

        // R2 disabled updates are ignored
        send(5, 3, 300); send(9, 1, 64); idle(3);

        // R2 R3 enabled updates
        reg_write(8'h00, 32'h1);
        en_model = 1;
        reg_read(8'h00, rd); check("R7 ctrl enable", 192'(rd), 192'(1));
        check("R2 meas_en", 192'(meas_en), 192'(1));
        for (int k = 1; k <= 5; k++) send(7, k, 1500 * k);       // R3 same bin back to back
        for (int k = 0; k < 4; k++) begin                          // R5 high word carry
            send(0, 2, 32'hFFFF_FFF0);
            send(255, 1, 32'hFFFF_FFF0);
        end
        send(128, 9, 900); idle(1); send(128, 1, 64); idle(2);
        send(3, 1, 64); send(3, 1, 64); send(4, 1, 64); send(3, 1, 64); // R3 interleaved
        idle(4);

        // R4 R5 R6 readout with counting continuing
        start_readout();
        reg_read(8'h00, rd); check("R7 ctrl readout busy", 192'(rd), 192'(3));
        fork
            drain_readout("R5 R2 R3 first");
            begin
                idle(1);
                send(7, 4, 400); send(7, 4, 400); send(200, 1, 70);
                idle(20);
                send(1, 2, 128);
                idle(2);
            end
        join
        reg_read(8'h00, rd); check("R6 bit1 clears", 192'(rd), 192'(1));

        // R6 ack while idle is ignored
        reg_write(8'h04, 32'h1);
        idle(3);

        // R4 second readout holds only updates made since the swap
        start_readout();
        drain_readout("R4 R6 second");

        // R10 soft reset
        send(11, 5, 5000); send(12, 6, 6000); idle(4);
        reg_write(8'h00, 32'h80);
        en_model = 0;
        model_clear_all();
        reg_read(8'h00, rd); check("R10 ctrl zero", 192'(rd), 192'(0));
        reg_read(8'h08, rd); check("R10 gap kept", 192'(rd), 192'(32'h15));
        check("R10 meas_en", 192'(meas_en), 192'(0));
        reg_write(8'h00, 32'h1);
        en_model = 1;
        idle(2);
        start_readout();
        drain_readout("R10 empty after reset");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule